// File: doc/BRIEF.md
# Multi-Channel Underflow Reload Timer

A memory-mapped timer with two or three independent 32-bit down-counters. Every channel has a reload value, a live counter and a control word. The control word picks the count-clock divider, enables an interrupt and holds a sticky underflow flag. A single shared start byte has one run bit per channel, so software starts and stops any channel by read-modify-write of that byte.

Each running channel divides the block clock with its own prescaler and decrements its counter on every prescaled tick. When a tick finds the counter at zero, the counter reloads from its reload value and the flag sets in the same cycle. Loading all ones into both registers therefore gives a free-running full-range count. The flag drives the channel's interrupt output when the enable bit is set, and software acknowledges it by writing the flag bit as zero.

The bus side is a synchronous single-cycle port with byte enables. Reads are combinational from the address and have no side effects.

Top module: `mc_reload_timer`

## Requirements
- R1: After reset the start byte and every control word read 0, every reload value and counter reads 0xFFFFFFFF, and all interrupt outputs are low.
- R2: Register map (byte addresses, 32-bit words). The start byte is bits [7:0] of word 4. Channel N has its reload value at 8+12N, its counter at 12+12N and its control word at 16+12N. Unmapped words read 0. Writes take effect at the next edge and update only the byte lanes whose `be_i` bit is set. A write whose address has bits [1:0] nonzero is ignored. A bus write to a counter overrides a tick in the same cycle.
- R3: Start byte bit N is the run bit of channel N (written through lane 0). While it is clear, channel N's counter holds its value and stays writable.
- R4: Control bits [2:0] pick the divider: 0 gives /4, 1 gives /16, 2 gives /64, 3 gives /256, and 4 to 7 give /1024. A running channel ticks once every divider-count cycles.
- R5: On a tick with a nonzero counter, the counter decrements by one.
- R6: On a tick with a zero counter, the counter loads the reload value and control bit 8 (the flag) sets, both at the same edge.
- R7: `irq_o[N]` is high exactly when channel N's flag and control bit 5 (interrupt enable) are both set. It stays high until software clears either bit.
- R8: A control write with lane 1 enabled and bit 8 at 0 clears the flag. Writing bit 8 as 1 leaves it unchanged. A set and a clear at the same edge leave the flag set. Bits [2:0] and 5 are written through lane 0.
- R9: Channels count independently: one channel's run bit, divider and registers have no effect on another channel.
- R10: Clearing a run bit resets that channel's prescaler. After the channel restarts, the first decrement lands exactly one full divider period after the edge that set the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | Access is a write |
| addr_i | input | ADDR_W | Byte address |
| be_i | input | 4 | Byte-lane enables for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | NUM_CH | Per-channel underflow interrupt |

## Verification
The assertions assume that a counter, reload or control value changes only through an aligned bus write, and that bus inputs are stable around the clock edge. The bench meets this by driving every input on the falling edge and holding it through the next rising edge. It uses only word-aligned addresses, except for one deliberately unaligned write that must be dropped. A behavioural model shadows every register and prescaler and checks `rdata_o` and `irq_o` on each cycle. Directed sequences place a flag clear on the same edge as an underflow, and count the cycles from a restart to the first decrement.

// File: rtl/mcrt_pkg.sv
package mcrt_pkg;
  localparam int DW     = 32;
  localparam int CTL_W  = 16;
  localparam int SEL_W  = 3;
  localparam int PRE_W  = 10;
  localparam int IE_BIT = 5;
  localparam int FL_BIT = 8;

  // terminal prescaler count for a divider code
  function automatic logic [PRE_W-1:0] pre_last(input logic [SEL_W-1:0] sel);
    logic [PRE_W:0] div;
    if (sel[2]) return '1;
    div = (PRE_W+1)'(4) << {sel[1:0], 1'b0};
    return PRE_W'(div - 1'b1);
  endfunction

  function automatic logic [DW-1:0] byte_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [DW/8-1:0] be);
    logic [DW-1:0] r;
    r = old_v;
    for (int b = 0; b < DW/8; b++)
      if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/mcrt_prescaler.sv
module mcrt_prescaler
  import mcrt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q >= pre_last(sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mcrt_channel.sv
module mcrt_channel
  import mcrt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wr_rld_i,
  input  logic             wr_cnt_i,
  input  logic             wr_ctl_i,
  input  logic [DW/8-1:0]  be_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rld_o,
  output logic [DW-1:0]    cnt_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             tick_o,
  output logic             flag_o,
  output logic             ie_o,
  output logic             irq_o
);
  logic [DW-1:0]    rld_q, cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             ie_q, flag_q;
  logic             tick, under, clr;

  mcrt_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  assign under = tick && (cnt_q == '0);
  assign clr   = wr_ctl_i && be_i[1] && !wdata_i[FL_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_q  <= '1;
      cnt_q  <= '1;
      sel_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_rld_i) rld_q <= byte_merge(rld_q, wdata_i, be_i);
      if (wr_cnt_i)      cnt_q <= byte_merge(cnt_q, wdata_i, be_i);
      else if (under)    cnt_q <= rld_q;
      else if (tick)     cnt_q <= cnt_q - 1'b1;
      if (wr_ctl_i && be_i[0]) begin
        sel_q <= wdata_i[SEL_W-1:0];
        ie_q  <= wdata_i[IE_BIT];
      end
      flag_q <= under || (flag_q && !clr); // set wins
    end
  end

  always_comb begin
    ctl_o            = '0;
    ctl_o[SEL_W-1:0] = sel_q;
    ctl_o[IE_BIT]    = ie_q;
    ctl_o[FL_BIT]    = flag_q;
  end

  assign rld_o  = rld_q;
  assign cnt_o  = cnt_q;
  assign tick_o = tick;
  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign irq_o  = flag_q && ie_q;
endmodule

// File: rtl/mc_reload_timer.sv
module mc_reload_timer
  import mcrt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int WORD_W     = ADDR_W - 2;
  localparam int START_WORD = 1;
  localparam int BANK_BASE  = 2;
  localparam int BANK_WORDS = 3;

  function automatic logic [WORD_W-1:0] bank_word(input int ch, input int k);
    return WORD_W'(BANK_BASE + BANK_WORDS*ch + k);
  endfunction

  logic [WORD_W-1:0]           word;
  logic                        wr_en;
  logic [NUM_CH-1:0]           run_q;
  logic [NUM_CH-1:0]           wr_rld, wr_cnt, wr_ctl;
  logic [NUM_CH-1:0]           tick_w, flag_w, ie_w;
  logic [NUM_CH-1:0][DW-1:0]   rld_w, cnt_w;
  logic [NUM_CH-1:0][CTL_W-1:0] ctl_w;

  assign word  = addr_i[ADDR_W-1:2];
  assign wr_en = req_i && we_i && (addr_i[1:0] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (wr_en && word == WORD_W'(START_WORD) && be_i[0])
      run_q <= wdata_i[NUM_CH-1:0];
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign wr_rld[n] = wr_en && (word == bank_word(n, 0));
    assign wr_cnt[n] = wr_en && (word == bank_word(n, 1));
    assign wr_ctl[n] = wr_en && (word == bank_word(n, 2));

    mcrt_channel u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_q[n]),
      .wr_rld_i (wr_rld[n]),
      .wr_cnt_i (wr_cnt[n]),
      .wr_ctl_i (wr_ctl[n]),
      .be_i     (be_i),
      .wdata_i  (wdata_i),
      .rld_o    (rld_w[n]),
      .cnt_o    (cnt_w[n]),
      .ctl_o    (ctl_w[n]),
      .tick_o   (tick_w[n]),
      .flag_o   (flag_w[n]),
      .ie_o     (ie_w[n]),
      .irq_o    (irq_o[n])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (word == WORD_W'(START_WORD)) rdata_o[NUM_CH-1:0] = run_q;
    for (int n = 0; n < NUM_CH; n++) begin
      if (word == bank_word(n, 0)) rdata_o = rld_w[n];
      if (word == bank_word(n, 1)) rdata_o = cnt_w[n];
      if (word == bank_word(n, 2)) rdata_o = {16'h0, ctl_w[n]};
    end
  end
endmodule

// File: rtl/mcrt_checker.sv
module mcrt_checker
  import mcrt_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_CH-1:0]         run_q,
  input logic [NUM_CH-1:0]         tick_w,
  input logic [NUM_CH-1:0]         flag_w,
  input logic [NUM_CH-1:0]         ie_w,
  input logic [NUM_CH-1:0]         wr_cnt,
  input logic [NUM_CH-1:0]         wr_ctl,
  input logic [NUM_CH-1:0][DW-1:0] cnt_w,
  input logic [NUM_CH-1:0][DW-1:0] rld_w,
  input logic                      lane0_i,
  input logic                      lane1_i,
  input logic                      flag_wd_i,
  input logic [NUM_CH-1:0]         irq_o
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    a_r3_stopped_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_q[n] && !wr_cnt[n] |=> $stable(cnt_w[n]));
    a_r4_no_tick_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_q[n] |-> !tick_w[n]);
    a_r5_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_w[n] && cnt_w[n] != '0 && !wr_cnt[n] |=> cnt_w[n] == $past(cnt_w[n]) - 1);
    a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_w[n] && cnt_w[n] == '0 && !wr_cnt[n] |=> cnt_w[n] == $past(rld_w[n]));
    a_r6_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_w[n] && cnt_w[n] == '0 |=> flag_w[n]);
    a_r8_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_w[n]) |-> $past(tick_w[n] && cnt_w[n] == '0));
    a_r7_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[n] && !(wr_ctl[n] && (lane0_i || (lane1_i && !flag_wd_i))) |=> irq_o[n]);
    a_r7_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[n] |-> flag_w[n] && ie_w[n]);
  end
endmodule

bind mc_reload_timer mcrt_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_q     (run_q),
  .tick_w    (tick_w),
  .flag_w    (flag_w),
  .ie_w      (ie_w),
  .wr_cnt    (wr_cnt),
  .wr_ctl    (wr_ctl),
  .cnt_w     (cnt_w),
  .rld_w     (rld_w),
  .lane0_i   (be_i[0]),
  .lane1_i   (be_i[1]),
  .flag_wd_i (wdata_i[8]),
  .irq_o     (irq_o)
);

// File: tb/mc_reload_timer_test.sv
`timescale 1ns/1ps
module mc_reload_timer_test;
  localparam int N = 3;
  localparam int AW = 6;

  logic          clk = 0, rst_n = 0;
  logic          req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    be = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  irq;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  mc_reload_timer #(.NUM_CH(N), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  // behavioural reference model
  int          m_pc  [N];
  logic [31:0] m_cnt [N];
  logic [31:0] m_rld [N];
  logic [2:0]  m_sel [N];
  bit          m_ie  [N];
  bit          m_fl  [N];
  logic [N-1:0] m_run;

  function automatic int divider(input logic [2:0] s);
    case (s)
      3'd0: return 4;
      3'd1: return 16;
      3'd2: return 64;
      3'd3: return 256;
      default: return 1024;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d,
                                        input logic [3:0] e);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (e[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    int w = int'(a >> 2);
    if (w == 1) return {{(32-N){1'b0}}, m_run};
    for (int c = 0; c < N; c++) begin
      if (w == 2 + 3*c) return m_rld[c];
      if (w == 3 + 3*c) return m_cnt[c];
      if (w == 4 + 3*c) return 32'(m_sel[c]) | (32'(m_ie[c]) << 5) | (32'(m_fl[c]) << 8);
    end
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = '0;
      for (int c = 0; c < N; c++) begin
        m_pc[c] = 0; m_cnt[c] = '1; m_rld[c] = '1;
        m_sel[c] = 0; m_ie[c] = 0; m_fl[c] = 0;
      end
    end else begin
      int w;
      bit wr;
      w  = int'(addr >> 2);
      wr = req && we && (addr[1:0] == 2'b00);
      for (int c = 0; c < N; c++) begin
        bit tk, setf, clr;
        tk = m_run[c] && (m_pc[c] >= divider(m_sel[c]) - 1);
        if (!m_run[c] || tk) m_pc[c] = 0; else m_pc[c]++;
        setf = tk && (m_cnt[c] == 0);
        if (wr && w == 3 + 3*c) m_cnt[c] = merge(m_cnt[c], wdata, be);
        else if (tk) m_cnt[c] = (m_cnt[c] == 0) ? m_rld[c] : m_cnt[c] - 1;
        if (wr && w == 2 + 3*c) m_rld[c] = merge(m_rld[c], wdata, be);
        clr = wr && (w == 4 + 3*c) && be[1] && !wdata[8];
        if (wr && w == 4 + 3*c && be[0]) begin
          m_sel[c] = wdata[2:0];
          m_ie[c]  = wdata[5];
        end
        m_fl[c] = setf || (m_fl[c] && !clr);
      end
      if (wr && w == 1 && be[0]) m_run = wdata[N-1:0];
    end
  end

  task automatic chk(input bit ok, input string t, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h (t=%0t)", t, got, exp, $time);
    end
  endtask

  task automatic compare();
    logic [N-1:0] ei;
    for (int c = 0; c < N; c++) ei[c] = m_fl[c] && m_ie[c];
    chk(irq === ei, {tag, " irq"}, 32'(irq), 32'(ei));
    chk(rdata === m_read(addr), {tag, " rdata"}, rdata, m_read(addr));
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] e, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; be = e; wdata = d;
    #1 compare();
    @(posedge clk);
    #1 req = 0; we = 0; be = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string t);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 compare();
    chk(rdata === exp, t, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req = 0; we = 0;
      #1 compare();
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++; checks++;
      $display("FAIL watchdog: got %0d cycles expected under 200000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    tag = "R1";
    rd(4,  32'h0,        "R1 start");
    rd(8,  32'hFFFFFFFF, "R1 rld0");
    rd(12, 32'hFFFFFFFF, "R1 cnt0");
    rd(16, 32'h0,        "R1 ctl0");
    rd(40, 32'h0,        "R1 ctl2");
    chk(irq === '0, "R1 irq", 32'(irq), 0);
    // R2 byte lanes, map, unaligned write
    tag = "R2";
    wr(8, 4'b0001, 32'h123456AB);
    rd(8, 32'hFFFFFFAB, "R2 lane merge");
    wr(8, 4'b1111, 32'd5);
    wr(9, 4'b1111, 32'd0);
    rd(8, 32'd5, "R2 unaligned ignored");
    wr(12, 4'b1111, 32'd2);
    rd(12, 32'd2, "R2 cnt0 write");
    wr(16, 4'b0011, 32'h20);
    rd(16, 32'h20, "R2 ctl0 write");
    rd(0, 32'h0, "R2 unmapped");
    // R3 stopped channel holds
    tag = "R3";
    idle(10);
    rd(12, 32'd2, "R3 stopped hold");
    // R5/R6/R7 count to underflow
    tag = "R6";
    wr(4, 4'b0001, 32'h1);
    idle(20);
    rd(16, 32'h120, "R6 flag set");
    chk(irq[0] === 1'b1, "R7 irq0 high", 32'(irq), 1);
    tag = "R7";
    idle(30);
    chk(irq[0] === 1'b1, "R7 irq0 held", 32'(irq), 1);
    // R8 flag write semantics
    tag = "R8";
    wr(4, 4'b0001, 32'h0);
    wr(16, 4'b0011, 32'h120);
    rd(16, 32'h120, "R8 write one keeps flag");
    wr(16, 4'b0011, 32'h020);
    rd(16, 32'h020, "R8 write zero clears");
    chk(irq[0] === 1'b0, "R8 irq0 low", 32'(irq), 0);
    // R10 restart latency
    tag = "R10";
    wr(12, 4'b1111, 32'd10);
    wr(4, 4'b0001, 32'h1);
    rd(12, 32'd10, "R10 c1");
    rd(12, 32'd10, "R10 c2");
    rd(12, 32'd10, "R10 c3");
    rd(12, 32'd10, "R10 c4");
    rd(12, 32'd9,  "R10 first tick");
    // R8 set wins over clear on same edge
    tag = "R8";
    wr(4, 4'b0001, 32'h0);
    wr(12, 4'b1111, 32'd0);
    wr(4, 4'b0001, 32'h1);
    idle(6);
    wr(4, 4'b0001, 32'h0);
    rd(16, 32'h120, "R8 flag before race");
    wr(12, 4'b1111, 32'd0);
    wr(4, 4'b0001, 32'h1);
    rd(12, 32'd0, "R8 pre1");
    rd(12, 32'd0, "R8 pre2");
    rd(12, 32'd0, "R8 pre3");
    wr(16, 4'b0011, 32'h020);
    rd(16, 32'h120, "R8 set wins");
    rd(12, 32'd5, "R6 reload value");
    wr(4, 4'b0001, 32'h0);
    // R4/R9 other channels, other dividers
    tag = "R9";
    wr(20, 4'b1111, 32'd3);
    wr(24, 4'b1111, 32'd3);
    wr(28, 4'b0011, 32'h21);
    wr(32, 4'b1111, 32'd1);
    wr(36, 4'b1111, 32'd1);
    wr(40, 4'b0011, 32'h27);
    wr(4, 4'b0001, 32'h6);
    idle(3000);
    rd(12, 32'd5, "R9 ch0 untouched");
    tag = "R4";
    wr(28, 4'b0011, 32'h22);
    idle(1500);
    wr(28, 4'b0011, 32'h23);
    idle(1500);
    wr(36, 4'b1111, 32'd7);
    rd(36, 32'd7, "R4 ch2 write while running");
    idle(100);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule